// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing mode of an 8-bit processor instruction into the 16-bit address of its operand. A start strobe hands it the mode, the two index registers and the address of the first operand byte. It then reads the operand bytes, and for the indirect modes the two pointer bytes, over a synchronous byte read port. The port returns data in the cycle after the request. When the address is ready the block raises a one-cycle done strobe. With that strobe it gives the effective address, a flag that tells the core's cycle accounting an index or branch moved into another page, and the number of bytes the program counter must skip.

The eight modes are immediate, zero page, zero page indexed, absolute, absolute indexed, pre-indexed indirect, post-indexed indirect and relative branch. Arithmetic that stays inside page zero wraps at 8 bits. Arithmetic on a full address carries into the upper byte. The block only forms the address: it does not run the instruction.

Top module: `eag_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `busy`, `mem_rd`, `page_cross` are low and `ea` and `pc_adv` are zero.
- R2: Mode codes on `mode` are 0 immediate, 1 zero page, 2 zero page indexed, 3 absolute, 4 absolute indexed, 5 pre-indexed indirect, 6 post-indexed indirect and 7 relative. `idx_sel` picks X (0) or Y (1) for modes 2 and 4. Operand bytes are read low byte at `pc`, then high byte at `pc`+1. Reads happen only while `busy`. An operation issues 0, 1, 2 or 3 reads for modes {0}, {1,2,7}, {3,4} and {5,6}.
- R3: Immediate mode gives `ea` = `pc` and issues no read.
- R4: Modes 1 and 2 give `ea` = {0x00, (op + index) mod 256}, with index taken as 0 in mode 1. An operand of 0xFF plus an index of 1 gives 0x0000.
- R5: Modes 3 and 4 give `ea` = {op_hi, op_lo} + zero-extended index, modulo 2^16. In mode 4, `page_cross` is high when the upper byte of `ea` differs from op_hi (0x12FF + 1 gives 0x1300 with `page_cross` high).
- R6: Mode 5 reads the pointer low byte at {0x00, (op + X) mod 256} and the high byte at the next page-zero location, wrapping from 0xFF to 0x00. `ea` is that pointer.
- R7: Mode 6 reads the pointer at {0x00, op} and the next page-zero location (same wrap). `ea` = pointer + Y modulo 2^16, with `page_cross` high when the upper byte changes.
- R8: Mode 7 gives `ea` = (`pc` + 1) + sign-extended op, modulo 2^16, with `page_cross` high when its upper byte differs from that of `pc` + 1.
- R9: `pc_adv` is 2 for modes 3 and 4 and 1 for every other mode.
- R10: `done` is a single-cycle pulse that comes 1, 3, 4 or 6 clock edges after the edge that samples `start`, for modes {0}, {1,2,7}, {3,4} and {5,6}. `busy` is high from the edge that takes `start` until `done` rises, and it is low while `done` is high.
- R11: `start` is ignored while `busy` is high. Changes to the mode, index or `pc` inputs after the start edge do not affect the result. `ea`, `page_cross` and `pc_adv` hold their values until the next `done`.
- R12: `page_cross` is low for modes 0, 1, 2, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address calculation (taken only when idle) |
| mode | input | 3 | Addressing mode code |
| idx_sel | input | 1 | Index choice for modes 2 and 4: 0 X, 1 Y |
| x_idx | input | 8 | X index register value |
| y_idx | input | 8 | Y index register value |
| pc | input | 16 | Address of the first operand byte |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Index or branch changed the upper address byte |
| pc_adv | output | 2 | Operand bytes to skip in the program counter |

## Verification
The strobe is due a fixed number of edges after the start edge: one for immediate, three for the one-byte modes, four for absolute and six for the indirect modes. The bench counts edges from the start edge, sampling on falling edges, and compares the count it reaches when `done` is first seen against that figure. It reads `ea`, `page_cross` and `pc_adv` in that same sampling slot. The memory model logs each request, so the number and order of reads are checked against the mode. One falling edge later the bench checks that the strobe has dropped and the results still hold.

// File: rtl/eag_pkg.sv
`timescale 1ns/1ps
package eag_pkg;

   typedef enum logic [2:0] {
      AM_IMM  = 3'd0,
      AM_ZP   = 3'd1,
      AM_ZPI  = 3'd2,
      AM_ABS  = 3'd3,
      AM_ABI  = 3'd4,
      AM_PRE  = 3'd5,
      AM_POST = 3'd6,
      AM_REL  = 3'd7
   } amode_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OP0,
      ST_OP1,
      ST_OPW,
      ST_P0,
      ST_P1,
      ST_PW,
      ST_CALC
   } seq_st_t;

   // capture code k+1 loads byte slot k
   typedef enum logic [2:0] {
      CAP_NONE = 3'd0,
      CAP_OPLO = 3'd1,
      CAP_OPHI = 3'd2,
      CAP_PLO  = 3'd3,
      CAP_PHI  = 3'd4
   } cap_t;

   localparam int SLOT_OPLO = 0;
   localparam int SLOT_OPHI = 1;
   localparam int SLOT_PLO  = 2;
   localparam int SLOT_PHI  = 3;
   localparam int NUM_SLOTS = 4;

   function automatic logic is_two_byte(input amode_t m);
      return (m == AM_ABS) || (m == AM_ABI);
   endfunction

   function automatic logic is_via_ptr(input amode_t m);
      return (m == AM_PRE) || (m == AM_POST);
   endfunction

endpackage

// File: rtl/eag_bytes.sv
`timescale 1ns/1ps
module eag_bytes
   import eag_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NSLOT  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  cap_t                         cap,
   input  logic [DATA_W-1:0]            rdata,
   output logic [NSLOT-1:0][DATA_W-1:0] slots
);

   if (NSLOT < 1 || NSLOT > 7) begin : g_bad_nslot
      $error("eag_bytes: NSLOT must be 1..7");
   end

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      localparam logic [2:0] CODE = 3'(i + 1);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slots[i] <= '0;
         end else if (cap == cap_t'(CODE)) begin
            slots[i] <= rdata;
         end
      end
   end

endmodule

// File: rtl/eag_seq.sv
`timescale 1ns/1ps
module eag_seq
   import eag_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 16,
   parameter bit PTR_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode_i,
   input  logic              isel_i,
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [DATA_W-1:0] op_lo,
   output amode_t            mode_q,
   output logic              isel_q,
   output logic [DATA_W-1:0] x_q,
   output logic [DATA_W-1:0] y_q,
   output logic [ADDR_W-1:0] pc_q,
   output logic              busy,
   output logic              calc,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output cap_t              cap_q
);

   localparam int PG_W = ADDR_W - DATA_W;
   localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
   localparam logic [DATA_W-1:0] B_ONE = DATA_W'(1);

   seq_st_t           st_q, st_d;
   cap_t              cap_d;
   logic [DATA_W-1:0] zp0;
   logic [ADDR_W-1:0] ptr0_addr, ptr1_addr;

   // pointer location in page zero; pre-indexed adds X before the lookup
   assign zp0       = (mode_q == AM_PRE) ? (op_lo + x_q) : op_lo;
   assign ptr0_addr = {{PG_W{1'b0}}, zp0};

   if (PTR_WRAP) begin : g_ptr_wrap
      assign ptr1_addr = {{PG_W{1'b0}}, zp0 + B_ONE};
   end else begin : g_ptr_carry
      assign ptr1_addr = ptr0_addr + A_ONE;
   end

   always_comb begin
      st_d     = st_q;
      cap_d    = CAP_NONE;
      mem_rd   = 1'b0;
      mem_addr = pc_q;
      case (st_q)
         ST_IDLE: begin
            if (start) begin
               st_d = (amode_t'(mode_i) == AM_IMM) ? ST_CALC : ST_OP0;
            end
         end
         ST_OP0: begin
            mem_rd = 1'b1;
            cap_d  = CAP_OPLO;
            st_d   = is_two_byte(mode_q) ? ST_OP1 : ST_OPW;
         end
         ST_OP1: begin
            mem_rd   = 1'b1;
            mem_addr = pc_q + A_ONE;
            cap_d    = CAP_OPHI;
            st_d     = ST_OPW;
         end
         ST_OPW: begin
            st_d = is_via_ptr(mode_q) ? ST_P0 : ST_CALC;
         end
         ST_P0: begin
            mem_rd   = 1'b1;
            mem_addr = ptr0_addr;
            cap_d    = CAP_PLO;
            st_d     = ST_P1;
         end
         ST_P1: begin
            mem_rd   = 1'b1;
            mem_addr = ptr1_addr;
            cap_d    = CAP_PHI;
            st_d     = ST_PW;
         end
         ST_PW:   st_d = ST_CALC;
         ST_CALC: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cap_q  <= CAP_NONE;
         mode_q <= AM_IMM;
         isel_q <= 1'b0;
         x_q    <= '0;
         y_q    <= '0;
         pc_q   <= '0;
      end else begin
         st_q  <= st_d;
         cap_q <= cap_d;
         if (st_q == ST_IDLE && start) begin
            mode_q <= amode_t'(mode_i);
            isel_q <= isel_i;
            x_q    <= x_i;
            y_q    <= y_i;
            pc_q   <= pc_i;
         end
      end
   end

   assign busy = (st_q != ST_IDLE);
   assign calc = (st_q == ST_CALC);

endmodule

// File: rtl/eag_calc.sv
`timescale 1ns/1ps
module eag_calc
   import eag_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int ADV_W  = 2
) (
   input  amode_t            mode,
   input  logic              isel,
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] op_lo,
   input  logic [DATA_W-1:0] op_hi,
   input  logic [DATA_W-1:0] p_lo,
   input  logic [DATA_W-1:0] p_hi,
   output logic [ADDR_W-1:0] ea,
   output logic              xpage,
   output logic [ADV_W-1:0]  adv
);

   localparam int PG_W = ADDR_W - DATA_W;
   localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

   logic [DATA_W-1:0] idx;
   logic [ADDR_W-1:0] base;
   logic              xp_en;

   assign idx = isel ? y : x;

   always_comb begin
      base  = pc;
      ea    = pc;
      xp_en = 1'b0;
      adv   = ADV_W'(1);
      case (mode)
         AM_IMM: ea = pc;
         AM_ZP:  ea = {{PG_W{1'b0}}, op_lo};
         AM_ZPI: ea = {{PG_W{1'b0}}, op_lo + idx};
         AM_ABS: begin
            ea  = {op_hi, op_lo};
            adv = ADV_W'(2);
         end
         AM_ABI: begin
            base  = {op_hi, op_lo};
            ea    = base + {{PG_W{1'b0}}, idx};
            xp_en = 1'b1;
            adv   = ADV_W'(2);
         end
         AM_PRE: ea = {p_hi, p_lo};
         AM_POST: begin
            base  = {p_hi, p_lo};
            ea    = base + {{PG_W{1'b0}}, y};
            xp_en = 1'b1;
         end
         AM_REL: begin
            base  = pc + A_ONE;
            ea    = base + {{PG_W{op_lo[DATA_W-1]}}, op_lo};
            xp_en = 1'b1;
         end
         default: ea = pc;
      endcase
      xpage = xp_en && (ea[ADDR_W-1:DATA_W] != base[ADDR_W-1:DATA_W]);
   end

endmodule

// File: rtl/eag_top.sv
`timescale 1ns/1ps
module eag_top
   import eag_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 16,
   parameter bit PTR_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode,
   input  logic              idx_sel,
   input  logic [DATA_W-1:0] x_idx,
   input  logic [DATA_W-1:0] y_idx,
   input  logic [ADDR_W-1:0] pc,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] ea,
   output logic              page_cross,
   output logic [1:0]        pc_adv
);

   localparam int ADV_W = 2;

   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("eag_top: ADDR_W must be twice DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("eag_top: DATA_W must be at least 2");
   end

   amode_t                             mode_q;
   logic                               isel_q;
   logic [DATA_W-1:0]                  x_q, y_q;
   logic [ADDR_W-1:0]                  pc_q;
   logic                               calc;
   cap_t                               cap_q;
   logic [NUM_SLOTS-1:0][DATA_W-1:0]   slots;
   logic [ADDR_W-1:0]                  ea_c;
   logic                               xp_c;
   logic [ADV_W-1:0]                   adv_c;

   eag_seq #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .PTR_WRAP (PTR_WRAP)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mode_i   (mode),
      .isel_i   (idx_sel),
      .x_i      (x_idx),
      .y_i      (y_idx),
      .pc_i     (pc),
      .op_lo    (slots[SLOT_OPLO]),
      .mode_q   (mode_q),
      .isel_q   (isel_q),
      .x_q      (x_q),
      .y_q      (y_q),
      .pc_q     (pc_q),
      .busy     (busy),
      .calc     (calc),
      .mem_rd   (mem_rd),
      .mem_addr (mem_addr),
      .cap_q    (cap_q)
   );

   eag_bytes #(
      .DATA_W (DATA_W),
      .NSLOT  (NUM_SLOTS)
   ) u_bytes (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (cap_q),
      .rdata (mem_rdata),
      .slots (slots)
   );

   eag_calc #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .ADV_W  (ADV_W)
   ) u_calc (
      .mode  (mode_q),
      .isel  (isel_q),
      .x     (x_q),
      .y     (y_q),
      .pc    (pc_q),
      .op_lo (slots[SLOT_OPLO]),
      .op_hi (slots[SLOT_OPHI]),
      .p_lo  (slots[SLOT_PLO]),
      .p_hi  (slots[SLOT_PHI]),
      .ea    (ea_c),
      .xpage (xp_c),
      .adv   (adv_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done       <= 1'b0;
         ea         <= '0;
         page_cross <= 1'b0;
         pc_adv     <= '0;
      end else begin
         done <= calc;
         if (calc) begin
            ea         <= ea_c;
            page_cross <= xp_c;
            pc_adv     <= adv_c;
         end
      end
   end

endmodule

// File: rtl/eag_chk.sv
`timescale 1ns/1ps
module eag_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [2:0]        mode,
   input logic [ADDR_W-1:0] pc,
   input logic              busy,
   input logic              done,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] ea,
   input logic              page_cross,
   input logic [1:0]        pc_adv
);

   logic [2:0]        m_seen;
   logic [ADDR_W-1:0] pc_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_seen  <= 3'd0;
         pc_seen <= '0;
      end else if (start && !busy) begin
         m_seen  <= mode;
         pc_seen <= pc;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R10
   AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_rd); // R2
   AST_IMM_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && m_seen == 3'd0) |-> !mem_rd); // R3
   AST_IMM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && m_seen == 3'd0) |-> (ea == pc_seen)); // R3
   AST_ZP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (m_seen == 3'd1 || m_seen == 3'd2)) |-> (ea[ADDR_W-1:DATA_W] == '0)); // R4
   AST_ADV_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pc_adv == ((m_seen == 3'd3 || m_seen == 3'd4) ? 2'd2 : 2'd1))); // R9
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(ea) && $stable(page_cross) && $stable(pc_adv))); // R11
   AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && m_seen != 3'd4 && m_seen != 3'd6 && m_seen != 3'd7) |-> !page_cross); // R12

endmodule

bind eag_top eag_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_eag_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .mode       (mode),
   .pc         (pc),
   .busy       (busy),
   .done       (done),
   .mem_rd     (mem_rd),
   .ea         (ea),
   .page_cross (page_cross),
   .pc_adv     (pc_adv)
);

// File: tb/tb_eag_top.sv
`timescale 1ns/1ps
module tb_eag_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [2:0]  mode;
   logic        idx_sel;
   logic [7:0]  x_idx, y_idx;
   logic [15:0] pc;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata;
   logic        busy, done, page_cross;
   logic [15:0] ea;
   logic [1:0]  pc_adv;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   eag_top dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode       (mode),
      .idx_sel    (idx_sel),
      .x_idx      (x_idx),
      .y_idx      (y_idx),
      .pc         (pc),
      .mem_rd     (mem_rd),
      .mem_addr   (mem_addr),
      .mem_rdata  (mem_rdata),
      .busy       (busy),
      .done       (done),
      .ea         (ea),
      .page_cross (page_cross),
      .pc_adv     (pc_adv)
   );

   // memory model: arithmetic fill plus a few overrides
   logic        ov_en   [0:3];
   logic [15:0] ov_addr [0:3];
   logic [7:0]  ov_data [0:3];

   function automatic logic [7:0] mb(input logic [15:0] a);
      logic [7:0] v;
      v = a[7:0] * 8'd29 + a[15:8] * 8'd7 + 8'h35;
      for (int i = 0; i < 4; i++)
         if (ov_en[i] && ov_addr[i] == a) v = ov_data[i];
      return v;
   endfunction

   int          rd_total;
   logic [15:0] rd_log [0:7];

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mb(mem_addr);
      if (!rst_n) rd_total <= 0;
      else if (mem_rd) begin
         rd_log[rd_total[2:0]] <= mem_addr;
         rd_total <= rd_total + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_ov();
      for (int i = 0; i < 4; i++) ov_en[i] = 1'b0;
   endtask

   task automatic set_ov(input int i, input logic [15:0] a, input logic [7:0] d);
      ov_en[i] = 1'b1; ov_addr[i] = a; ov_data[i] = d;
   endtask

   task automatic run_op(input logic [2:0] m, input logic s, input logic [7:0] xv,
                         input logic [7:0] yv, input logic [15:0] pcv, input logic inject);
      logic [7:0]  op0, op1, idx, zp, zq;
      logic [15:0] base, e_ea;
      logic        e_x;
      logic [1:0]  e_adv;
      int          e_lat, e_rd, k, rd0;
      logic [15:0] e_addr [0:2];
      string       tag;
      op0 = mb(pcv); op1 = mb(pcv + 16'd1);
      idx = s ? yv : xv;
      base = pcv; e_ea = pcv; e_x = 1'b0; e_adv = 2'd1;
      e_lat = 3; e_rd = 1; e_addr[0] = pcv; e_addr[1] = 16'h0; e_addr[2] = 16'h0;
      tag = "R3";
      case (m)
         3'd0: begin e_lat = 1; e_rd = 0; end
         3'd1: begin tag = "R4"; e_ea = {8'h00, op0}; end
         3'd2: begin tag = "R4"; zp = op0 + idx; e_ea = {8'h00, zp}; end
         3'd3: begin tag = "R5"; e_ea = {op1, op0}; e_adv = 2'd2; e_lat = 4; e_rd = 2;
                     e_addr[1] = pcv + 16'd1; end
         3'd4: begin tag = "R5"; base = {op1, op0}; e_ea = base + {8'h00, idx};
                     e_x = (e_ea[15:8] != base[15:8]); e_adv = 2'd2; e_lat = 4; e_rd = 2;
                     e_addr[1] = pcv + 16'd1; end
         3'd5: begin tag = "R6"; zp = op0 + xv; zq = zp + 8'd1;
                     e_ea = {mb({8'h00, zq}), mb({8'h00, zp})}; e_lat = 6; e_rd = 3;
                     e_addr[1] = {8'h00, zp}; e_addr[2] = {8'h00, zq}; end
         3'd6: begin tag = "R7"; zp = op0; zq = zp + 8'd1;
                     base = {mb({8'h00, zq}), mb({8'h00, zp})}; e_ea = base + {8'h00, yv};
                     e_x = (e_ea[15:8] != base[15:8]); e_lat = 6; e_rd = 3;
                     e_addr[1] = {8'h00, zp}; e_addr[2] = {8'h00, zq}; end
         default: begin tag = "R8"; base = pcv + 16'd1;
                     e_ea = base + {{8{op0[7]}}, op0}; e_x = (e_ea[15:8] != base[15:8]); end
      endcase
      @(negedge clk);
      rd0 = rd_total;
      mode = m; idx_sel = s; x_idx = xv; y_idx = yv; pc = pcv; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R10 busy after start", {31'd0, busy}, 32'd1);
      // scramble inputs after the start edge; R11
      mode = 3'd0; pc = ~pcv; x_idx = ~xv; y_idx = ~yv; idx_sel = ~s;
      start = inject;
      k = 0;
      while (k < 20) begin
         @(posedge clk);
         k++;
         @(negedge clk);
         start = 1'b0;
         if (done) break;
      end
      chk("R10 latency", k, e_lat);
      chk("R10 busy low at done", {31'd0, busy}, 32'd0);
      chk(tag, {16'd0, ea}, {16'd0, e_ea});
      if (m == 3'd4 || m == 3'd6 || m == 3'd7) chk(tag, {31'd0, page_cross}, {31'd0, e_x});
      else chk("R12", {31'd0, page_cross}, 32'd0);
      chk("R9", {30'd0, pc_adv}, {30'd0, e_adv});
      chk("R2 read count", rd_total - rd0, e_rd);
      for (int i = 0; i < e_rd; i++)
         chk("R2 read address", {16'd0, rd_log[(rd0 + i) % 8]}, {16'd0, e_addr[i]});
      @(negedge clk);
      chk("R10 done single", {31'd0, done}, 32'd0);
      chk("R11 hold", {16'd0, ea}, {16'd0, e_ea});
      if (inject) begin
         rd0 = rd_total;
         repeat (7) begin
            @(negedge clk);
            chk("R11 ignored start", {30'd0, done, busy}, 32'd0);
         end
         chk("R11 no reads", rd_total - rd0, 0);
         chk("R11 hold", {16'd0, ea}, {16'd0, e_ea});
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [7:0]  xs  [0:4];
      logic [15:0] pcs [0:3];
      xs[0] = 8'h00; xs[1] = 8'h01; xs[2] = 8'h7F; xs[3] = 8'h80; xs[4] = 8'hFF;
      pcs[0] = 16'h0010; pcs[1] = 16'h12FE; pcs[2] = 16'h80FF; pcs[3] = 16'hFFFF;
      clear_ov();
      rst_n = 1'b0; start = 1'b0; mode = 3'd0; idx_sel = 1'b0;
      x_idx = 8'h0; y_idx = 8'h0; pc = 16'h0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset outputs", {busy, done, mem_rd, page_cross, pc_adv, ea},
          32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first cycle", {busy, done, mem_rd, page_cross, pc_adv, ea}, 32'd0);

      // sweep every mode, index select, index value and start address
      for (int m = 0; m < 8; m++)
         for (int s = 0; s < 2; s++)
            for (int xi = 0; xi < 5; xi++)
               for (int pi = 0; pi < 4; pi++)
                  run_op(3'(m), s[0], xs[xi], xs[xi] ^ 8'hA5, pcs[pi], 1'b0);

      // R4: page-zero index wraps 0xFF + 1 to 0x0000
      set_ov(0, 16'h0200, 8'hFF);
      run_op(3'd2, 1'b0, 8'h01, 8'h00, 16'h0200, 1'b0);
      chk("R4 wrap", {16'd0, ea}, 32'h0000);
      clear_ov();

      // R5: 0x12FF + 1 crosses into page 0x13
      set_ov(0, 16'h0300, 8'hFF); set_ov(1, 16'h0301, 8'h12);
      run_op(3'd4, 1'b0, 8'h01, 8'h00, 16'h0300, 1'b0);
      chk("R5 cross", {15'd0, page_cross, ea}, 32'h0001_1300);
      clear_ov();

      // R6: pointer at 0x00FF takes its high byte from 0x0000
      set_ov(0, 16'h0400, 8'hFE); set_ov(1, 16'h00FF, 8'h34); set_ov(2, 16'h0000, 8'h56);
      run_op(3'd5, 1'b0, 8'h01, 8'h00, 16'h0400, 1'b0);
      chk("R6 pointer wrap", {16'd0, ea}, 32'h5634);
      clear_ov();

      // R7: pointer 0x12FF plus Y = 1 crosses a page
      set_ov(0, 16'h0500, 8'h40); set_ov(1, 16'h0040, 8'hFF); set_ov(2, 16'h0041, 8'h12);
      run_op(3'd6, 1'b0, 8'h00, 8'h01, 16'h0500, 1'b0);
      chk("R7 cross", {15'd0, page_cross, ea}, 32'h0001_1300);
      clear_ov();

      // R8: backward branch of -2 from 0x1300 lands at 0x12FF
      set_ov(0, 16'h1300, 8'hFE);
      run_op(3'd7, 1'b0, 8'h00, 8'h00, 16'h1300, 1'b0);
      chk("R8 backward cross", {15'd0, page_cross, ea}, 32'h0001_12FF);
      clear_ov();

      // R11: start pulses during busy are ignored
      run_op(3'd3, 1'b0, 8'h00, 8'h00, 16'h2345, 1'b1);
      run_op(3'd0, 1'b0, 8'h00, 8'h00, 16'hBEEF, 1'b1);
      run_op(3'd6, 1'b1, 8'h10, 8'h20, 16'h0777, 1'b1);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule